// File: doc/BRIEF.md
# Byte-Addressed Program Counter with Staged Upper Bytes

This block keeps the fetch address of a processor core. The address is 21 bits wide and selects single bytes of program memory. Instructions are two bytes long, so bit 0 always stays zero and a sequential advance adds 2. Software can read and write only the low byte of the counter directly. The middle byte (bits 15:8) and the top five bits (bits 20:16) can change only through two holding latches. Software fills these latches first, and the next write to the low byte moves them into the counter. A read of the low byte works the other way and copies the current upper bits back into the latches. Computed jumps use this path. Direct control transfers (jump, call, relative call, branch) load a full target address and do not touch the latches.

Each cycle the counter takes one of four operations: `PC_HOLD` keeps the value, `PC_STEP` adds 2, `PC_LOWWR` assembles the value from the latches and the written low byte, and `PC_LOAD` takes the direct target. Each holding latch also takes one of three operations: `LT_HOLD` keeps its value, `LT_CAPTURE` copies its counter field on a low-byte read, and `LT_WRITE` stores software data. A fixed priority picks the operation, and all state changes at the clock edge.

Top module: `pcl_program_counter`

## Requirements
- R1: After reset the counter and both holding latches are zero.
- R2: With only `step_i` asserted, the counter is 2 greater after the clock edge.
- R3: Advancing from the highest even address 0x1FFFFE gives 0x000000.
- R4: A low-byte write sets bits 7:0 from `lo_wdata_i`, bits 15:8 from the middle latch and bits 20:16 from the upper latch, all in the same edge.
- R5: Bit 0 of the counter is always 0. An odd low-byte write value or an odd direct target has its bit 0 cleared.
- R6: `lo_rdata_o` always shows counter bits 7:0. A read strobe copies counter bits 15:8 into the middle latch and bits 20:16 into the upper latch at the edge.
- R7: A direct load (`load_i`) sets the counter to the target with bit 0 cleared. It leaves both latches unchanged.
- R8: Latch writes leave the counter unchanged. The middle latch stores all 8 bits. The upper latch stores bits 4:0 of `up_wdata_i` and ignores bits 7:5.
- R9: The counter operation priority is direct load, then low-byte write, then advance. A low-byte write uses the latch values from before any latch write in the same cycle.
- R10: When a low-byte read and a latch write occur in the same cycle, the read's capture wins for that latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Advance to the next instruction |
| lo_wr_i | input | 1 | Write strobe for the low byte |
| lo_wdata_i | input | 8 | Low-byte write data |
| lo_rd_i | input | 1 | Read strobe for the low byte; triggers the latch capture |
| mid_wr_i | input | 1 | Write strobe for the middle latch |
| mid_wdata_i | input | 8 | Middle latch write data |
| up_wr_i | input | 1 | Write strobe for the upper latch |
| up_wdata_i | input | 8 | Upper latch write data; bits 7:5 ignored |
| load_i | input | 1 | Direct load strobe for jumps, calls and branches |
| load_addr_i | input | 21 | Direct load target address |
| pc_o | output | 21 | Current counter value |
| lo_rdata_o | output | 8 | Low-byte read data (counter bits 7:0) |
| mid_latch_o | output | 8 | Middle holding latch |
| up_latch_o | output | 5 | Upper holding latch |

## Verification
Every state change (advance, low-byte write, direct load, latch write and latch capture) shows on the outputs one clock edge after the strobe. `lo_rdata_o` has no register and follows the counter in the same cycle. The bench drives inputs on the falling edge and lets one rising edge pass. It then checks the registered results on the next falling edge, where the new value is stable. It checks read data before that edge, while the strobe is still applied.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    localparam int BYTE_W  = 8;
    localparam int MID_LSB = 8;
    localparam int UP_LSB  = 16;

    typedef enum logic [1:0] {
        PC_HOLD  = 2'd0,
        PC_STEP  = 2'd1,
        PC_LOWWR = 2'd2,
        PC_LOAD  = 2'd3
    } pc_op_e;

    typedef enum logic [1:0] {
        LT_HOLD    = 2'd0,
        LT_CAPTURE = 2'd1,
        LT_WRITE   = 2'd2
    } lt_op_e;

endpackage

// File: rtl/pcl_op_select.sv
module pcl_op_select
    import pcl_pkg::*;
(
    input  logic   step_i,
    input  logic   lo_wr_i,
    input  logic   lo_rd_i,
    input  logic   mid_wr_i,
    input  logic   up_wr_i,
    input  logic   load_i,
    output pc_op_e pc_op_o,
    output lt_op_e mid_op_o,
    output lt_op_e up_op_o
);

    always_comb begin
        if (load_i) begin
            pc_op_o = PC_LOAD;
        end else if (lo_wr_i) begin
            pc_op_o = PC_LOWWR;
        end else if (step_i) begin
            pc_op_o = PC_STEP;
        end else begin
            pc_op_o = PC_HOLD;
        end
    end

    always_comb begin
        if (lo_rd_i) begin
            mid_op_o = LT_CAPTURE;
        end else if (mid_wr_i) begin
            mid_op_o = LT_WRITE;
        end else begin
            mid_op_o = LT_HOLD;
        end
    end

    always_comb begin
        if (lo_rd_i) begin
            up_op_o = LT_CAPTURE;
        end else if (up_wr_i) begin
            up_op_o = LT_WRITE;
        end else begin
            up_op_o = LT_HOLD;
        end
    end

endmodule

// File: rtl/pcl_hold_latch.sv
module pcl_hold_latch
    import pcl_pkg::*;
#(
    parameter int W    = 8,
    parameter int IN_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  lt_op_e          op_i,
    input  logic [W-1:0]    cap_val_i,
    input  logic [IN_W-1:0] wr_val_i,
    output logic [W-1:0]    q_o
);

    localparam logic [IN_W-1:0] KEEP = IN_W'((1 << W) - 1);

    logic [W-1:0] q_d;
    logic [W-1:0] q_q;

    always_comb begin
        unique case (op_i)
            LT_HOLD:    q_d = q_q;
            LT_CAPTURE: q_d = cap_val_i;
            LT_WRITE:   q_d = wr_val_i[W-1:0];
            default:    q_d = q_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign q_o = q_q;

    // R6: capture copies the counter field
    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == LT_CAPTURE) |=> (q_o == $past(cap_val_i)));

    // R8: write keeps only the low W bits of the data
    p_write_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == LT_WRITE) |=> (IN_W'(q_o) == ($past(wr_val_i) & KEEP)));

    // R7: without capture or write the latch holds its value
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == LT_HOLD) |=> $stable(q_o));

endmodule

// File: rtl/pcl_counter_core.sv
module pcl_counter_core
    import pcl_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int STEP   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  pc_op_e              op_i,
    input  logic [BYTE_W-1:0]   lo_wdata_i,
    input  logic [BYTE_W-1:0]   mid_latch_i,
    input  logic [ADDR_W-UP_LSB-1:0] up_latch_i,
    input  logic [ADDR_W-1:0]   target_i,
    output logic [ADDR_W-1:0]   pc_o
);

    localparam logic [ADDR_W-1:0] EVEN_MASK = ~ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_V    = ADDR_W'(STEP);

    logic [ADDR_W-1:0] pc_d;
    logic [ADDR_W-1:0] pc_q;
    logic [BYTE_W-1:0] lo_even;
    logic [ADDR_W-1:0] tgt_even;

    assign lo_even  = lo_wdata_i & 8'hFE;
    assign tgt_even = target_i & EVEN_MASK;

    always_comb begin
        unique case (op_i)
            PC_HOLD:  pc_d = pc_q;
            PC_STEP:  pc_d = pc_q + STEP_V;
            PC_LOWWR: pc_d = {up_latch_i, mid_latch_i, lo_even};
            PC_LOAD:  pc_d = tgt_even;
            default:  pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign pc_o = pc_q;

    // R5: never an odd address
    p_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_o[0] == 1'b0));

    // R2: advance by one instruction, wrapping (R3)
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == PC_STEP) |=> (pc_o == $past(pc_o) + STEP_V));

    // R7: direct load takes the target
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == PC_LOAD) |=> (pc_o[ADDR_W-1:1] == $past(target_i[ADDR_W-1:1])));

    // R4: low write merges latches and written byte
    p_lowwr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == PC_LOWWR) |=>
            (pc_o[UP_LSB-1:MID_LSB] == $past(mid_latch_i)) &&
            (pc_o[ADDR_W-1:UP_LSB] == $past(up_latch_i)) &&
            (pc_o[MID_LSB-1:1] == $past(lo_wdata_i[MID_LSB-1:1])));

endmodule

// File: rtl/pcl_program_counter.sv
module pcl_program_counter
    import pcl_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int STEP   = 2,
    localparam int UP_W  = ADDR_W - UP_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              lo_wr_i,
    input  logic [7:0]        lo_wdata_i,
    input  logic              lo_rd_i,
    input  logic              mid_wr_i,
    input  logic [7:0]        mid_wdata_i,
    input  logic              up_wr_i,
    input  logic [7:0]        up_wdata_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [7:0]        lo_rdata_o,
    output logic [7:0]        mid_latch_o,
    output logic [UP_W-1:0]   up_latch_o
);

    pc_op_e            pc_op;
    lt_op_e            mid_op;
    lt_op_e            up_op;
    logic [ADDR_W-1:0] pc;
    logic [7:0]        mid_q;
    logic [UP_W-1:0]   up_q;

    pcl_op_select i_sel (
        .step_i   (step_i),
        .lo_wr_i  (lo_wr_i),
        .lo_rd_i  (lo_rd_i),
        .mid_wr_i (mid_wr_i),
        .up_wr_i  (up_wr_i),
        .load_i   (load_i),
        .pc_op_o  (pc_op),
        .mid_op_o (mid_op),
        .up_op_o  (up_op)
    );

    pcl_hold_latch #(.W(BYTE_W), .IN_W(BYTE_W)) i_mid_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (mid_op),
        .cap_val_i (pc[UP_LSB-1:MID_LSB]),
        .wr_val_i  (mid_wdata_i),
        .q_o       (mid_q)
    );

    pcl_hold_latch #(.W(UP_W), .IN_W(BYTE_W)) i_up_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (up_op),
        .cap_val_i (pc[ADDR_W-1:UP_LSB]),
        .wr_val_i  (up_wdata_i),
        .q_o       (up_q)
    );

    pcl_counter_core #(.ADDR_W(ADDR_W), .STEP(STEP)) i_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (pc_op),
        .lo_wdata_i  (lo_wdata_i),
        .mid_latch_i (mid_q),
        .up_latch_i  (up_q),
        .target_i    (load_addr_i),
        .pc_o        (pc)
    );

    assign pc_o        = pc;
    assign lo_rdata_o  = pc[MID_LSB-1:0];
    assign mid_latch_o = mid_q;
    assign up_latch_o  = up_q;

    // R9: a direct load wins over a low-byte write and an advance
    p_load_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && (lo_wr_i || step_i)) |=> (pc_o[ADDR_W-1:1] == $past(load_addr_i[ADDR_W-1:1])));

    // R10: a read capture beats a same-cycle latch write
    p_read_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_rd_i && mid_wr_i) |=> (mid_latch_o == $past(pc_o[UP_LSB-1:MID_LSB])));

endmodule

// File: tb/test_pcl_program_counter.sv
module test_pcl_program_counter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic        lo_wr_i = 1'b0;
    logic [7:0]  lo_wdata_i = '0;
    logic        lo_rd_i = 1'b0;
    logic        mid_wr_i = 1'b0;
    logic [7:0]  mid_wdata_i = '0;
    logic        up_wr_i = 1'b0;
    logic [7:0]  up_wdata_i = '0;
    logic        load_i = 1'b0;
    logic [20:0] load_addr_i = '0;
    logic [20:0] pc_o;
    logic [7:0]  lo_rdata_o;
    logic [7:0]  mid_latch_o;
    logic [4:0]  up_latch_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcl_program_counter i_pcl_program_counter (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .lo_wr_i(lo_wr_i),
        .lo_wdata_i(lo_wdata_i), .lo_rd_i(lo_rd_i), .mid_wr_i(mid_wr_i),
        .mid_wdata_i(mid_wdata_i), .up_wr_i(up_wr_i), .up_wdata_i(up_wdata_i),
        .load_i(load_i), .load_addr_i(load_addr_i), .pc_o(pc_o),
        .lo_rdata_o(lo_rdata_o), .mid_latch_o(mid_latch_o), .up_latch_o(up_latch_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        step_i = 0; lo_wr_i = 0; lo_rd_i = 0; mid_wr_i = 0; up_wr_i = 0; load_i = 0;
    endtask

    // one rising edge, then settle at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        check("R1", "pc", int'(pc_o), 0);
        check("R1", "mid latch", int'(mid_latch_o), 0);
        check("R1", "up latch", int'(up_latch_o), 0);
    endtask

    task automatic t_advance();
        for (int k = 1; k <= 3; k++) begin
            step_i = 1; tick();
            check("R2", "pc after step", int'(pc_o), 2 * k);
        end
    endtask

    task automatic t_latch_write();
        mid_wr_i = 1; mid_wdata_i = 8'h34; up_wr_i = 1; up_wdata_i = 8'hFF; tick();
        check("R8", "mid latch", int'(mid_latch_o), 'h34);
        check("R8", "up latch top bits ignored", int'(up_latch_o), 'h1F);
        check("R8", "pc unchanged", int'(pc_o), 6);
    endtask

    task automatic t_low_write();
        lo_wr_i = 1; lo_wdata_i = 8'h57; tick();
        check("R4", "pc merged from latches", int'(pc_o), 'h1F3456);
        check("R5", "odd low byte made even", int'(pc_o[0]), 0);
    endtask

    task automatic t_load();
        load_i = 1; load_addr_i = 21'h012345; tick();
        check("R7", "pc from target", int'(pc_o), 'h012344);
        check("R7", "mid latch untouched", int'(mid_latch_o), 'h34);
        check("R7", "up latch untouched", int'(up_latch_o), 'h1F);
    endtask

    task automatic t_read();
        lo_rd_i = 1;
        #1;
        check("R6", "read data", int'(lo_rdata_o), 'h44);
        tick();
        check("R6", "mid captured", int'(mid_latch_o), 'h23);
        check("R6", "up captured", int'(up_latch_o), 'h01);
    endtask

    task automatic t_wrap();
        load_i = 1; load_addr_i = 21'h1FFFFE; tick();
        check("R3", "at top", int'(pc_o), 'h1FFFFE);
        step_i = 1; tick();
        check("R3", "wrapped", int'(pc_o), 0);
    endtask

    task automatic t_priority();
        load_i = 1; load_addr_i = 21'h0ABCD0; lo_wr_i = 1; lo_wdata_i = 8'h10; step_i = 1; tick();
        check("R9", "load beats write and step", int'(pc_o), 'h0ABCD0);
        lo_wr_i = 1; lo_wdata_i = 8'h20; step_i = 1; tick();
        check("R9", "write beats step", int'(pc_o), 'h012320);
        lo_wr_i = 1; lo_wdata_i = 8'h40; mid_wr_i = 1; mid_wdata_i = 8'h99;
        up_wr_i = 1; up_wdata_i = 8'h07; tick();
        check("R9", "write uses old latches", int'(pc_o), 'h012340);
        check("R9", "mid latch updated", int'(mid_latch_o), 'h99);
        check("R9", "up latch updated", int'(up_latch_o), 'h07);
    endtask

    task automatic t_read_vs_write();
        lo_rd_i = 1; mid_wr_i = 1; mid_wdata_i = 8'hEE; up_wr_i = 1; up_wdata_i = 8'h1A; tick();
        check("R10", "mid capture wins", int'(mid_latch_o), 'h23);
        check("R10", "up capture wins", int'(up_latch_o), 'h01);
        check("R10", "pc unchanged", int'(pc_o), 'h012340);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_advance();
        t_latch_write();
        t_low_write();
        t_load();
        t_read();
        t_wrap();
        t_priority();
        t_read_vs_write();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule